// File: doc/BRIEF.md
# Transport Stream Packet Aligner and PID Gate

This block sits on a byte-wide transport stream and decides, packet by packet, whether each one travels on or is thrown away. It tracks packet boundaries with a position counter, and it confirms them against a programmable sync token seen at each packet start. Lock is declared after a run of good starts and is withdrawn after a run of bad ones. While lock is not held, an input start-of-packet flag realigns the counter. Nothing is forwarded while the block is unlocked.

The packet identifier is taken as a programmable bit slice of a 64-bit word. The first eight bytes of the packet form that word, with byte 0 as the most significant byte. The identifier indexes a one-bit-per-identifier enable table, which a simple write port can set or clear bit by bit. A global filter enable bypasses the table and lets every good packet through. The decision is made when byte 7 arrives. The first eight bytes are held back until then, so a packet always leaves whole or not at all.

Both stream interfaces are valid/ready. A byte moves when valid and ready are high together at a clock edge. Once the output raises valid, it holds valid, data and both flags steady until ready is seen. Upstream must obey the same rule. During a forwarded packet's held-back header, input ready stays low. After the header, input ready follows output ready combinationally. While a packet is being collected or dropped, input ready is high.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, out_valid and locked are 0, in_ready is 1, and every table bit is clear.
- R2: Each accepted byte at packet position 0 is compared with cfg_token. When unlocked, a match adds one to a hit count and a mismatch zeroes it. locked rises on the edge that accepts the start byte bringing the count to cfg_lock_thr, and that packet is already eligible.
- R3: When locked, a mismatching start byte adds one to a miss count and a matching one zeroes it. locked falls on the edge that accepts the start byte bringing the count to cfg_drop_thr.
- R4: No byte is output while locked is 0, and a packet whose start byte differs from cfg_token is never output.
- R5: The identifier is bits [cfg_pid_ofs+n-1 : cfg_pid_ofs] of the 64-bit word made from bytes 0..7, with byte 0 in bits 63:56. Here n is cfg_pid_bits capped at 13, and bit positions above 63 read as 0.
- R6: With cfg_filt_en=1, a locked, well-started packet is output only when the table bit at its identifier is 1.
- R7: With cfg_filt_en=0, every locked, well-started packet is output, whatever the table holds.
- R8: A cycle with tbl_we=1 writes tbl_set into table bit tbl_idx, and it leaves all other bits unchanged.
- R9: A forwarded packet leaves as exactly cfg_pkt_len bytes, in input order. out_sop marks the first byte and out_eop marks the last.
- R10: While out_valid=1 and out_ready=0, the output holds steady. While the held header is being sent, in_ready is 0.
- R11: While unlocked, an accepted byte with in_sop=1 is taken as packet position 0.
- R12: The packet length is set by cfg_pkt_len, which must be at least 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is a packet start (used while unlocked) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_eop | output | 1 | Last byte of a forwarded packet |
| locked | output | 1 | Packet alignment is held |
| cfg_token | input | 8 | Expected start byte |
| cfg_lock_thr | input | 4 | Good starts needed to lock |
| cfg_drop_thr | input | 4 | Bad starts needed to unlock |
| cfg_pkt_len | input | 8 | Packet length in bytes |
| cfg_pid_ofs | input | 6 | Identifier slice offset in the header word |
| cfg_pid_bits | input | 4 | Identifier slice width |
| cfg_filt_en | input | 1 | 1: use the table, 0: pass all |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 13 | Table bit to write |
| tbl_set | input | 1 | Value to write |

## Verification
A wrong position count appears within one packet time. Forwarded packets then show a misplaced out_eop or a wrong length, or the start bytes fail to match and lock drops after cfg_drop_thr packets. A wrong hit or miss count moves the locked edge by whole packets, and this shows as one packet too many or too few at the output. A corrupt table bit or a wrong identifier slice drops or admits the very packet that hits it, once its byte 7 arrives. A fault in the header buffer corrupts the first eight bytes of each forwarded packet.

// File: rtl/ts_pf_pkg.sv
package ts_pf_pkg;
  typedef enum logic [1:0] {
    ST_HDR,    // collecting header bytes 0..7
    ST_DRAIN,  // sending held header bytes
    ST_PASS,   // streaming rest of a kept packet
    ST_SKIP    // discarding rest of a packet
  } pf_state_e;

  localparam int HDR_BYTES = 8;
  localparam int HDR_BITS  = HDR_BYTES * 8;
endpackage

// File: rtl/ts_pid_table.sv
module ts_pid_table #(
  parameter int PID_W  = 13,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PID_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [PID_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int SEL_W = $clog2(WORD_W);
  localparam int ROW_W = PID_W - SEL_W;
  localparam int ROWS  = 1 << ROW_W;

  logic [WORD_W-1:0] bits_q [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) bits_q[r] <= '0;
    end else if (wr_en) begin
      bits_q[wr_idx[PID_W-1:SEL_W]][wr_idx[SEL_W-1:0]] <= wr_val;
    end
  end

  assign rd_bit = bits_q[rd_idx[PID_W-1:SEL_W]][rd_idx[SEL_W-1:0]];
endmodule

// File: rtl/ts_pid_slicer.sv
module ts_pid_slicer #(
  parameter int PID_W = 13,
  parameter int OFS_W = 6,
  parameter int NB_W  = 4
) (
  input  logic [ts_pf_pkg::HDR_BITS-1:0] hdr_word,
  input  logic [OFS_W-1:0]               ofs,
  input  logic [NB_W-1:0]                nbits,
  output logic [PID_W-1:0]               pid
);
  localparam logic [NB_W-1:0] NB_CAP = NB_W'(PID_W);

  logic [ts_pf_pkg::HDR_BITS-1:0] shifted;
  logic [NB_W-1:0]                nb_eff;

  assign shifted = hdr_word >> ofs;
  assign nb_eff  = (nbits > NB_CAP) ? NB_CAP : nbits;

  for (genvar i = 0; i < PID_W; i++) begin : g_bit
    assign pid[i] = shifted[i] & (NB_W'(i) < nb_eff);
  end
endmodule

// File: rtl/ts_sync_tracker.sv
module ts_sync_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_stb,
  input  logic             start_match,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] drop_thr,
  output logic             locked
);
  logic [CNT_W-1:0] hits_q, miss_q;
  logic [CNT_W:0]   hits_nx, miss_nx;

  assign hits_nx = {1'b0, hits_q} + 1'b1;
  assign miss_nx = {1'b0, miss_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      hits_q <= '0;
      miss_q <= '0;
    end else if (start_stb) begin
      if (!locked) begin
        if (!start_match) begin
          hits_q <= '0;
        end else if (hits_nx >= {1'b0, lock_thr}) begin
          locked <= 1'b1;
          hits_q <= '0;
          miss_q <= '0;
        end else begin
          hits_q <= hits_nx[CNT_W-1:0];
        end
      end else begin
        if (start_match) begin
          miss_q <= '0;
        end else if (miss_nx >= {1'b0, drop_thr}) begin
          locked <= 1'b0;
          miss_q <= '0;
          hits_q <= '0;
        end else begin
          miss_q <= miss_nx[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_pf_pkg::*;
#(
  parameter int PID_W  = 13,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4,
  parameter int OFS_W  = 6,
  parameter int NB_W   = 4,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             locked,
  input  logic [7:0]       cfg_token,
  input  logic [CNT_W-1:0] cfg_lock_thr,
  input  logic [CNT_W-1:0] cfg_drop_thr,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [OFS_W-1:0] cfg_pid_ofs,
  input  logic [NB_W-1:0]  cfg_pid_bits,
  input  logic             cfg_filt_en,
  input  logic             tbl_we,
  input  logic [PID_W-1:0] tbl_idx,
  input  logic             tbl_set
);
  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);

  pf_state_e        st_q;
  logic [LEN_W-1:0] pos_q, eff_pos, pkt_last;
  logic [IDX_W-1:0] didx_q;
  logic [7:0]       hdr_q [HDR_BYTES];
  logic             start_ok_q;
  logic             hdr_phase, in_accept, start_stb, start_match;
  logic [HDR_BITS-1:0] hdr_word;
  logic [PID_W-1:0] pid;
  logic             tbl_bit, keep;

  assign hdr_phase   = (st_q == ST_HDR) || (st_q == ST_SKIP);
  assign in_accept   = in_valid && in_ready;
  assign eff_pos     = (!locked && in_sop) ? '0 : pos_q;
  assign pkt_last    = cfg_pkt_len - 1'b1;
  assign start_match = (in_data == cfg_token);
  assign start_stb   = hdr_phase && in_accept && (eff_pos == '0);

  // header word: held bytes 0..6 plus the byte arriving now as byte 7
  always_comb begin
    hdr_word = '0;
    for (int b = 0; b < HDR_BYTES - 1; b++)
      hdr_word[HDR_BITS-1-8*b -: 8] = hdr_q[b];
    hdr_word[7:0] = in_data;
  end

  ts_sync_tracker #(.CNT_W(CNT_W)) u_sync (
    .clk, .rst_n,
    .start_stb, .start_match,
    .lock_thr(cfg_lock_thr), .drop_thr(cfg_drop_thr),
    .locked
  );

  ts_pid_slicer #(.PID_W(PID_W), .OFS_W(OFS_W), .NB_W(NB_W)) u_slice (
    .hdr_word, .ofs(cfg_pid_ofs), .nbits(cfg_pid_bits), .pid
  );

  ts_pid_table #(.PID_W(PID_W), .WORD_W(WORD_W)) u_tbl (
    .clk, .rst_n,
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_val(tbl_set),
    .rd_idx(pid), .rd_bit(tbl_bit)
  );

  assign keep = locked && start_ok_q && (!cfg_filt_en || tbl_bit);

  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = in_data;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    case (st_q)
      ST_DRAIN: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = hdr_q[didx_q];
        out_sop   = (didx_q == '0);
      end
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_eop   = (pos_q == pkt_last);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < HDR_BYTES; b++) hdr_q[b] <= '0;
    end else if (hdr_phase && in_accept && eff_pos <= HDR_LAST) begin
      hdr_q[eff_pos[IDX_W-1:0]] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HDR;
      pos_q      <= '0;
      didx_q     <= '0;
      start_ok_q <= 1'b0;
    end else begin
      case (st_q)
        ST_HDR, ST_SKIP: if (in_accept) begin
          if (eff_pos == '0) start_ok_q <= start_match;
          if (eff_pos == pkt_last) begin
            st_q  <= ST_HDR;
            pos_q <= '0;
          end else if (eff_pos == HDR_LAST) begin
            pos_q  <= eff_pos + 1'b1;
            didx_q <= '0;
            st_q   <= keep ? ST_DRAIN : ST_SKIP;
          end else begin
            pos_q <= eff_pos + 1'b1;
            st_q  <= (eff_pos < HDR_LAST) ? ST_HDR : ST_SKIP;
          end
        end
        ST_DRAIN: if (out_ready) begin
          didx_q <= didx_q + 1'b1;
          if (didx_q == IDX_W'(HDR_BYTES - 1)) st_q <= ST_PASS;
        end
        ST_PASS: if (in_accept) begin
          if (pos_q == pkt_last) begin
            st_q  <= ST_HDR;
            pos_q <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: st_q <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       locked,
  input logic [7:0] cfg_token
);
  a_r4_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !out_valid);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  a_r10_no_intake_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !in_ready);

  a_r9_sop_not_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop));

  a_r9_gap_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> !out_valid);

  a_r2_lock_on_token: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && in_ready && in_data == cfg_token));

  a_r3_unlock_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid && in_ready && in_data != cfg_token));
endmodule

bind ts_pid_filter ts_pid_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
  .locked(locked), .cfg_token(cfg_token)
);

// File: tb/ts_pid_filter_test.sv
module ts_pid_filter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_sop, out_valid, out_ready;
  logic [7:0]  in_data, out_data, cfg_token, cfg_pkt_len;
  logic        out_sop, out_eop, locked, cfg_filt_en, tbl_we, tbl_set;
  logic [3:0]  cfg_lock_thr, cfg_drop_thr, cfg_pid_bits;
  logic [5:0]  cfg_pid_ofs;
  logic [12:0] tbl_idx;

  ts_pid_filter uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop, .locked,
    .cfg_token, .cfg_lock_thr, .cfg_drop_thr, .cfg_pkt_len,
    .cfg_pid_ofs, .cfg_pid_bits, .cfg_filt_en, .tbl_we, .tbl_idx, .tbl_set
  );

  // row = {good start, pid, expected forwarded}; lock/drop thresholds 2
  localparam logic [14:0] VEC [12] = '{
    {1'b1, 13'h0100, 1'b0},  // hit 1, unlocked
    {1'b1, 13'h0100, 1'b1},  // hit 2 -> lock, bit set
    {1'b1, 13'h0055, 1'b0},  // bit clear
    {1'b1, 13'h1FFF, 1'b1},  // top bit set
    {1'b0, 13'h0100, 1'b0},  // miss 1
    {1'b1, 13'h0100, 1'b1},  // miss count cleared
    {1'b0, 13'h0100, 1'b0},  // miss 1
    {1'b0, 13'h0100, 1'b0},  // miss 2 -> unlock
    {1'b1, 13'h0100, 1'b0},  // hit 1
    {1'b1, 13'h0100, 1'b1},  // relock
    {1'b1, 13'h0000, 1'b0},
    {1'b1, 13'h1FFF, 1'b1}
  };

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit stall_mode = 0, wd_hit = 0;
  logic [7:0] sbuf [1024]; logic ssop [1024]; int slen;
  logic [7:0] ebuf [1024]; logic esop [1024]; logic eeop [1024]; int elen;
  logic [7:0] obuf [1024]; logic osop [1024]; logic oeop [1024]; int olen;
  int rowpos [12];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_bufs();
    slen = 0; elen = 0; olen = 0;
  endtask

  task automatic add_raw(input logic [7:0] v);
    sbuf[slen] = v; ssop[slen] = 1'b0; slen++;
  endtask

  task automatic add_pkt(input logic [7:0] b0, b1, b2, b3, input int len,
                         input bit fwd, input int tag);
    for (int k = 0; k < len; k++) begin
      logic [7:0] v;
      v = (k == 0) ? b0 : (k == 1) ? b1 : (k == 2) ? b2 : (k == 3) ? b3 : 8'(tag * 16 + k);
      sbuf[slen] = v; ssop[slen] = (k == 0); slen++;
      if (fwd) begin
        ebuf[elen] = v; esop[elen] = (k == 0); eeop[elen] = (k == len - 1); elen++;
      end
    end
  endtask

  task automatic run_stream();
    int i = 0, tail = 0;
    while (tail < 12) begin
      @(negedge clk);
      if (i < slen) begin
        in_valid = 1'b1; in_data = sbuf[i]; in_sop = ssop[i];
      end else begin
        in_valid = 1'b0; in_sop = 1'b0; tail++;
      end
      out_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (out_valid && out_ready && olen < 1024) begin
        obuf[olen] = out_data; osop[olen] = out_sop; oeop[olen] = out_eop; olen++;
      end
      if (in_valid && in_ready) i++;
      cyc++;
      if (cyc > 100000) begin
        if (!wd_hit) check(1'b0, "watchdog", cyc, 100000);
        wd_hit = 1;
        tail = 12;
      end
    end
  endtask

  task automatic compare_all(input string req);
    bit ok = (olen == elen);
    for (int k = 0; k < elen && k < olen; k++)
      if (obuf[k] != ebuf[k] || osop[k] != esop[k] || oeop[k] != eeop[k]) ok = 0;
    check(ok, req, olen, elen);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = '0; out_ready = 1'b1;
    tbl_we = 1'b0; tbl_idx = '0; tbl_set = 1'b0;
    cfg_token = 8'h47; cfg_pkt_len = 8'd12; cfg_lock_thr = 4'd2; cfg_drop_thr = 4'd2;
    cfg_pid_ofs = 6'd40; cfg_pid_bits = 4'd13; cfg_filt_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tbl_write(input logic [12:0] idx, input logic val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_set = val;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_vectors(input bit stall);
    do_reset();
    stall_mode = stall;
    tbl_write(13'h0100, 1'b1);
    tbl_write(13'h1FFF, 1'b1);
    clear_bufs();
    for (int r = 0; r < 12; r++) begin
      logic [14:0] v;
      v = VEC[r];
      rowpos[r] = elen;
      add_pkt(v[14] ? 8'h47 : 8'h46, {3'b000, v[13:9]}, v[8:1], 8'h00, 12, v[0], r);
    end
    run_stream();
    for (int r = 0; r < 12; r++) begin
      if (VEC[r][0]) begin
        bit ok = 1;
        for (int k = 0; k < 12; k++) begin
          int ix = rowpos[r] + k;
          if (ix >= olen || obuf[ix] != ebuf[ix] || osop[ix] != (k == 0) || oeop[ix] != (k == 11))
            ok = 0;
        end
        check(ok, stall ? "R10 row packet under stall" : "R6/R9 row packet", ok, 1);
      end
    end
    check(olen == elen, "R2/R3/R4 forwarded byte count", olen, elen);
    #2 check(locked == 1'b1, "R2 relocked at end", locked, 1);
    stall_mode = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    // table-driven runs: lock, drop, filtering, back-pressure
    run_vectors(1'b0);
    run_vectors(1'b1);

    // R1: reset state
    do_reset();
    #2;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(locked == 1'b0, "R1 locked after reset", locked, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    // R1: table clear -> nothing passes with filter on
    clear_bufs();
    for (int p = 0; p < 3; p++) add_pkt(8'h47, 8'h01, 8'h00, 8'h00, 12, 1'b0, p);
    run_stream();
    check(olen == 0, "R1 table clear after reset", olen, 0);

    // R2: lock threshold 3
    do_reset();
    cfg_lock_thr = 4'd3;
    clear_bufs();
    for (int p = 0; p < 2; p++) add_pkt(8'h47, 8'h00, 8'h10, 8'h00, 12, 1'b0, p);
    run_stream();
    check(locked == 1'b0, "R2 not locked one short of threshold", locked, 0);
    clear_bufs();
    add_pkt(8'h47, 8'h00, 8'h10, 8'h00, 12, 1'b0, 2);
    run_stream();
    check(locked == 1'b1, "R2 locked at threshold", locked, 1);

    // R7: filter disabled passes unlisted pid
    cfg_filt_en = 1'b0;
    clear_bufs();
    add_pkt(8'h47, 8'h00, 8'h55, 8'h00, 12, 1'b1, 3);
    run_stream();
    compare_all("R7 bypass forwards all");
    cfg_filt_en = 1'b1;

    // R5: slice offset 32 width 8 selects byte 3
    cfg_pid_ofs = 6'd32; cfg_pid_bits = 4'd8;
    tbl_write(13'h002A, 1'b1);
    clear_bufs();
    add_pkt(8'h47, 8'h00, 8'h00, 8'h2A, 12, 1'b1, 4);
    add_pkt(8'h47, 8'h00, 8'h00, 8'h2B, 12, 1'b0, 5);
    run_stream();
    compare_all("R5 slice of byte 3");
    // R5: offset 60 width 8 -> top nibble of byte 0, upper bits zero
    cfg_pid_ofs = 6'd60;
    tbl_write(13'h0004, 1'b1);
    clear_bufs();
    add_pkt(8'h47, 8'h99, 8'h77, 8'h00, 12, 1'b1, 6);
    run_stream();
    compare_all("R5 slice past bit 63 reads zero");

    // R8: set and clear individual bits
    cfg_pid_ofs = 6'd40; cfg_pid_bits = 4'd13;
    tbl_write(13'h0100, 1'b1);
    tbl_write(13'h0101, 1'b1);
    tbl_write(13'h0100, 1'b0);
    clear_bufs();
    add_pkt(8'h47, 8'h01, 8'h00, 8'h00, 12, 1'b0, 7);
    add_pkt(8'h47, 8'h01, 8'h01, 8'h00, 12, 1'b1, 8);
    run_stream();
    compare_all("R8 cleared bit drops, neighbour kept");

    // R12: packet length 20
    cfg_pkt_len = 8'd20;
    clear_bufs();
    add_pkt(8'h47, 8'h01, 8'h01, 8'h00, 20, 1'b1, 9);
    add_pkt(8'h47, 8'h01, 8'h01, 8'h00, 20, 1'b1, 10);
    run_stream();
    compare_all("R12/R9 length 20 packets");

    // R11: realign on in_sop while unlocked after stray bytes
    do_reset();
    cfg_filt_en = 1'b0;
    clear_bufs();
    add_raw(8'h11); add_raw(8'h22); add_raw(8'h33);
    add_pkt(8'h47, 8'h00, 8'h00, 8'h00, 12, 1'b0, 11);
    add_pkt(8'h47, 8'h00, 8'h00, 8'h00, 12, 1'b1, 12);
    add_pkt(8'h47, 8'h00, 8'h00, 8'h00, 12, 1'b1, 13);
    run_stream();
    compare_all("R11 realign on start flag");
    check(locked == 1'b1, "R11 locked after realign", locked, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule